// File: doc/BRIEF.md
# Time-Shared Single-Port FIFO

This block is a synchronous first-in first-out queue. Its storage is one single-port memory, so each clock cycle allows at most one memory access, either a read or a write. A write pointer and a read pointer address that memory, and an occupancy counter tracks how many entries are held. The input-ready and output-available flags are taken from that counter. A writer and a reader run on the same clock and share the memory port in time. A small arbiter gives the port to one side each cycle. A side that asks and is not served sees its wait output high. It must then hold its request and its data unchanged until wait drops.

The arbiter is a two-state machine. In state `ARB_WR_FIRST` a contested cycle goes to the writer. In state `ARB_RD_FIRST` a contested cycle goes to the reader. A cycle is contested when both sides request and both could be served: the queue is neither full nor empty. There are three transitions. The transition *write wins contest* moves `ARB_WR_FIRST` to `ARB_RD_FIRST`. The transition *read wins contest* moves `ARB_RD_FIRST` to `ARB_WR_FIRST`. On *no contest*, the state holds. Reset enters `ARB_WR_FIRST`. When only one side is eligible, that side is served whatever the state. Read data is registered and appears one cycle after the granted read, together with a one-cycle valid pulse.

Top module: `sp_shared_fifo`

## Requirements
- R1: While synchronous reset `rst` is high, both wait outputs are low even if both requests are high. After reset the queue is empty: `wr_ready`=1, `rd_avail`=0 and `rd_valid`=0.
- R2: Data words leave the queue in the order in which their writes were granted.
- R3: `wr_ready` is 0 exactly when the queue holds DEPTH entries. A write request while full is not granted, `wr_wait` is 1, and the queue contents are unchanged.
- R4: `rd_avail` is 0 exactly when the queue is empty. A read request while empty is not granted, `rd_wait` is 1, and no `rd_valid` pulse follows.
- R5: At most one of the two requests is granted in any cycle. A request is granted when it is high and its wait output is low.
- R6: The first contested cycle after reset is granted to the write. Each later contested cycle goes to the side that lost the previous contested cycle. Uncontested cycles do not change which side comes next.
- R7: `wr_wait` is 1 exactly when `wr_req` is 1 and the write is not granted, and likewise for `rd_wait`. A side that loses a contest is served in the following cycle if both sides still request.
- R8: `rd_valid` is 1 in the cycle after a granted read and 0 otherwise. In that cycle `rd_data` carries the word that was read.
- R9: Each granted write raises the occupancy by one and each granted read lowers it by one. After a granted write `rd_avail` is 1, and after a granted read `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Write request; held while `wr_wait` is high |
| wr_data | input | WIDTH | Word to store; held while `wr_wait` is high |
| wr_ready | output | 1 | Queue has room for at least one word |
| wr_wait | output | 1 | Write requested but not taken this cycle |
| rd_req | input | 1 | Read request; held while `rd_wait` is high |
| rd_data | output | WIDTH | Registered read word |
| rd_avail | output | 1 | Queue holds at least one word |
| rd_wait | output | 1 | Read requested but not taken this cycle |
| rd_valid | output | 1 | `rd_data` holds the word of the read granted last cycle |

## Verification
A write and a read can both ask for the single memory port in the same cycle. The bench provokes this by raising both requests over several back-to-back cycles while the queue is partly filled. It also does so with the queue empty and with it full, where only one side is eligible. Each cycle is judged by which wait output is high, checked against the alternation the priority state should produce. The judgement also covers whether the loser is served one cycle later with its held word, and whether the words read back keep write order.

// File: rtl/spf_pkg.sv
package spf_pkg;

    // Priority state of the port arbiter: which side wins a contested cycle.
    typedef enum logic {
        ARB_WR_FIRST = 1'b0,
        ARB_RD_FIRST = 1'b1
    } arb_state_e;

endpackage

// File: rtl/spf_arbiter.sv
module spf_arbiter
    import spf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_ok,   // write requested and queue not full
    input  logic rd_ok,   // read requested and queue not empty
    output logic gnt_wr,
    output logic gnt_rd
);

    arb_state_e state_q, state_d;
    logic       contest;

    assign contest = wr_ok && rd_ok;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ARB_WR_FIRST;
        else     state_q <= state_d;
    end

    // Next state: a contest hands priority to the other side
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_WR_FIRST: if (contest) state_d = ARB_RD_FIRST;
            ARB_RD_FIRST: if (contest) state_d = ARB_WR_FIRST;
            default:      state_d = ARB_WR_FIRST;
        endcase
    end

    // Grants
    always_comb begin
        gnt_wr = 1'b0;
        gnt_rd = 1'b0;
        if (!rst) begin
            unique case (state_q)
                ARB_WR_FIRST: begin
                    gnt_wr = wr_ok;
                    gnt_rd = rd_ok && !wr_ok;
                end
                ARB_RD_FIRST: begin
                    gnt_rd = rd_ok;
                    gnt_wr = wr_ok && !rd_ok;
                end
                default: begin
                    gnt_wr = 1'b0;
                    gnt_rd = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/spf_occupancy.sv
module spf_occupancy #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       gnt_wr,
    input  logic                       gnt_rd,
    output logic [$clog2(DEPTH)-1:0]   wr_ptr,
    output logic [$clog2(DEPTH)-1:0]   rd_ptr,
    output logic                       not_full,
    output logic                       not_empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [AW-1:0] wr_nxt, rd_nxt;
    logic [CW-1:0] count_q;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_cmp_wrap
            assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (gnt_wr) begin
                wr_ptr  <= wr_nxt;
                count_q <= count_q + 1'b1;
            end else if (gnt_rd) begin
                rd_ptr  <= rd_nxt;
                count_q <= count_q - 1'b1;
            end
        end
    end

    assign not_full  = (count_q != FULL_CNT);
    assign not_empty = (count_q != '0);

endmodule

// File: rtl/spf_spram.sv
module spf_spram #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [WIDTH-1:0]         din,
    output logic [WIDTH-1:0]         dout
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) mem[addr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst)             dout <= '0;
        else if (en && !we)  dout <= mem[addr];
    end

endmodule

// File: rtl/sp_shared_fifo.sv
module sp_shared_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ready,
    output logic             wr_wait,
    input  logic             rd_req,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_avail,
    output logic             rd_wait,
    output logic             rd_valid
);

    localparam int AW = $clog2(DEPTH);

    logic          gnt_wr, gnt_rd;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          not_full, not_empty;
    logic          rd_valid_q;

    spf_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk       (clk),
        .rst       (rst),
        .gnt_wr    (gnt_wr),
        .gnt_rd    (gnt_rd),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .not_full  (not_full),
        .not_empty (not_empty)
    );

    spf_arbiter u_arb (
        .clk    (clk),
        .rst    (rst),
        .wr_ok  (wr_req && not_full),
        .rd_ok  (rd_req && not_empty),
        .gnt_wr (gnt_wr),
        .gnt_rd (gnt_rd)
    );

    spf_spram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk  (clk),
        .rst  (rst),
        .en   (gnt_wr || gnt_rd),
        .we   (gnt_wr),
        .addr (gnt_wr ? wr_ptr : rd_ptr),
        .din  (wr_data),
        .dout (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_valid_q <= 1'b0;
        else     rd_valid_q <= gnt_rd;
    end

    assign wr_ready = not_full;
    assign rd_avail = not_empty;
    assign wr_wait  = !rst && wr_req && !gnt_wr;
    assign rd_wait  = !rst && rd_req && !gnt_rd;
    assign rd_valid = rd_valid_q;

endmodule

// File: rtl/spf_checker.sv
module spf_checker (
    input logic clk,
    input logic rst,
    input logic wr_req,
    input logic wr_ready,
    input logic wr_wait,
    input logic rd_req,
    input logic rd_avail,
    input logic rd_wait,
    input logic rd_valid
);

    logic wr_taken, rd_taken, contest;
    assign wr_taken = wr_req && !wr_wait;
    assign rd_taken = rd_req && !rd_wait;
    assign contest  = wr_req && rd_req && wr_ready && rd_avail;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (wr_ready && !rd_avail && !rd_valid));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ready) |-> wr_wait);

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_avail) |-> rd_wait);

    p_one_access_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_taken && rd_taken));

    p_contest_one_loser_r6: assert property (@(posedge clk) disable iff (rst)
        contest |-> (wr_wait != rd_wait));

    p_wr_loser_next_r7: assert property (@(posedge clk) disable iff (rst)
        (contest && wr_wait) |=> !(wr_req && rd_req && wr_wait));

    p_rd_loser_next_r7: assert property (@(posedge clk) disable iff (rst)
        (contest && rd_wait) |=> !(wr_req && rd_req && rd_wait));

    p_valid_after_read_r8: assert property (@(posedge clk) disable iff (rst)
        rd_taken |=> rd_valid);

    p_no_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_taken |=> !rd_valid);

    p_avail_after_write_r9: assert property (@(posedge clk) disable iff (rst)
        wr_taken |=> rd_avail);

    p_room_after_read_r9: assert property (@(posedge clk) disable iff (rst)
        rd_taken |=> wr_ready);

endmodule

bind sp_shared_fifo spf_checker u_chk (.*);

// File: tb/sp_shared_fifo_bench.sv
module sp_shared_fifo_bench;

    localparam int W = 8;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_req = 1'b0, rd_req = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         wr_ready, wr_wait, rd_avail, rd_wait, rd_valid;
    logic [W-1:0] rd_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [W-1:0] model [$];

    always #10 clk = ~clk;

    sp_shared_fifo #(.WIDTH(W), .DEPTH(D)) u_sp_shared_fifo (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_data(wr_data), .wr_ready(wr_ready), .wr_wait(wr_wait),
        .rd_req(rd_req), .rd_data(rd_data), .rd_avail(rd_avail), .rd_wait(rd_wait),
        .rd_valid(rd_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, sample waits mid-cycle, sample registered
    // outputs at the next negedge. Model checks order and valid timing.
    task automatic step(input logic w, input logic [W-1:0] d, input logic r,
                        output logic ww, output logic rw);
        logic         exp_v;
        logic [W-1:0] exp_q;
        wr_req = w; wr_data = d; rd_req = r;
        #2;
        ww = wr_wait; rw = rd_wait;
        chk("R7 wr_wait only with wr_req", ww & ~w, 0);
        chk("R5 single access", (w & ~ww) & (r & ~rw), 0);
        exp_v = r && !rw;
        exp_q = '0;
        if (exp_v) exp_q = (model.size() > 0) ? model.pop_front() : 'x;
        if (w && !ww) model.push_back(d);
        @(negedge clk);
        chk("R8 rd_valid", rd_valid, exp_v);
        if (exp_v) chk("R2 order", rd_data, exp_q);
        if (w && !ww) chk("R9 avail after write", rd_avail, 1);
        if (exp_v)    chk("R9 room after read", wr_ready, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_req = 1'b1; rd_req = 1'b1;
        #2;
        chk("R1 wr_wait in reset", wr_wait, 0);
        chk("R1 rd_wait in reset", rd_wait, 0);
        repeat (2) @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0; rst = 1'b0;
        model.delete();
        chk("R1 wr_ready", wr_ready, 1);
        chk("R1 rd_avail", rd_avail, 0);
        chk("R1 rd_valid", rd_valid, 0);
    endtask

    task automatic drain();
        logic ww, rw;
        while (model.size() > 0) step(0, '0, 1, ww, rw);
        step(0, '0, 0, ww, rw);
        chk("R4 empty after drain", rd_avail, 0);
    endtask

    task automatic t_fill_drain();
        logic ww, rw;
        do_reset();
        for (int i = 0; i < D; i++) begin
            step(1, W'(8'h10 + i), 0, ww, rw);
            chk("R3 write accepted", ww, 0);
        end
        chk("R3 full flag", wr_ready, 0);
        step(1, 8'hEE, 0, ww, rw);
        chk("R3 write while full waits", ww, 1);
        drain();
        step(0, '0, 1, ww, rw);
        chk("R4 read while empty waits", rw, 1);
        step(0, '0, 0, ww, rw);
    endtask

    task automatic t_contend();
        logic ww, rw;
        do_reset();
        step(1, 8'hA0, 0, ww, rw);
        step(1, 8'hA1, 0, ww, rw);
        step(1, 8'hA2, 1, ww, rw);
        chk("R6 first contest write wins", {ww, rw}, 2'b01);
        step(1, 8'hA3, 1, ww, rw);
        chk("R7 read served after losing", {ww, rw}, 2'b10);
        step(1, 8'hA3, 1, ww, rw);
        chk("R6 write wins again", {ww, rw}, 2'b01);
        step(1, 8'hA4, 1, ww, rw);
        chk("R6 read wins again", {ww, rw}, 2'b10);
        step(1, 8'hA4, 0, ww, rw);
        chk("R6 lone write served", ww, 0);
        step(1, 8'hA5, 1, ww, rw);
        chk("R6 lone cycle keeps priority", {ww, rw}, 2'b01);
        drain();
    endtask

    task automatic t_edges();
        logic ww, rw;
        do_reset();
        step(1, 8'h55, 1, ww, rw);
        chk("R4 empty: write served, read waits", {ww, rw}, 2'b01);
        for (int i = 1; i < D; i++) step(1, W'(8'h60 + i), 0, ww, rw);
        chk("R3 full after fill", wr_ready, 0);
        step(1, 8'hEF, 1, ww, rw);
        chk("R3 full: read served, write waits", {ww, rw}, 2'b10);
        step(1, 8'hEF, 0, ww, rw);
        chk("R9 room reopened", ww, 0);
        drain();
    endtask

    initial begin
        t_fill_drain();
        t_contend();
        t_edges();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule